// File: doc/BRIEF.md
# Real-Time Clock and Calendar Counter

This block keeps the time of day and the calendar date. It counts pulses of a clock-enable input that comes from a 32.768 kHz timebase. A prescaler turns those pulses into a once-per-second step. The step then ripples through seconds, minutes and hours, and on into the day of the month, the month and the year. A separate weekday counter advances every time the date advances.

All fields are stored as two-digit BCD. The year runs from 00 to 99 and stands for 2000 to 2099. Across that span, a year whose value is a multiple of four is a leap year, so no century rule is needed.

A host sets the clock through a plain write port: one field per cycle, chosen by a 3-bit selector. Every field is visible all the time on its own output, so the host can read all of them in parallel. The write port has no handshake, because the block accepts a write in every cycle. Any write restarts the prescaler, which gives the host a full second before the first step after setting the time. Writing a value outside a field's legal range has no defined result.

Top module: `rtc_calendar`

## Requirements
- R1: The seconds field advances once for every PRESCALE_DIV cycles in which `osc_en` is high. While `osc_en` is low or the prescaler has not reached its end, no field changes.
- R2: All fields are BCD, with the lower digit in bits 3:0 and the upper digit in bits 7:4. After reset the block shows 00:00:00, date 01, month 01, year 00 and weekday 0. A lower digit of 9 increments to 0 and carries into the upper digit (09 -> 10).
- R3: On a step, seconds 59 wraps to 00 and advances minutes. Minutes 59 wraps to 00 and advances hours. Below 59, seconds and minutes increment with no carry.
- R4: On a step, hours 23 wraps to 00 and advances the date.
- R5: Date 30 wraps to 01 and advances the month in months 04, 06, 09 and 11. In every other month except 02, date 30 goes to 31 and date 31 wraps to 01.
- R6: In month 02, the last day is 29 when the year value is a multiple of four (including 00), and 28 otherwise.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: The weekday (0 to 6) advances in the same cycle as the date and in no other cycle, and it wraps from 6 to 0.
- R9: A write with `wr_en` high loads `wr_data` into the field chosen by `wr_sel` on the next clock edge, and leaves every other field as it was. The selector codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 weekday. Code 7 loads nothing.
- R10: A write of any code clears the prescaler. The next step therefore comes after PRESCALE_DIV further `osc_en` pulses, and no step happens in the write cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_en | input | 1 | One-cycle pulse per timebase period (32.768 kHz) |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field selector (0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 weekday) |
| wr_data | input | 8 | BCD value to load |
| secs | output | 8 | Seconds, BCD 00-59 |
| mins | output | 8 | Minutes, BCD 00-59 |
| hours | output | 8 | Hours, BCD 00-23 |
| mday | output | 8 | Day of month, BCD 01-31 |
| month | output | 8 | Month, BCD 01-12 |
| year | output | 8 | Year within 2000-2099, BCD 00-99 |
| wday | output | 8 | Weekday, 0-6 |

## Verification
The bench builds the block with PRESCALE_DIV set to 4 instead of 32768. A one-second step then costs four enable pulses, so every rollover is only a few cycles away. The bench loads a time such as 23:59:59 on a chosen date and takes a single step. This reaches the month-end, February, leap-year, December and year-99 boundaries, the weekday wrap, and the prescaler restart after a write, all within a short run.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_WDAY  = 3'd6
  } field_e;

  localparam int NUM_FIELDS = 7;

  // two-digit BCD increment with decimal carry between digits
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // within 2000-2099 a multiple of four is a leap year
  function automatic logic year_is_leap(input logic [7:0] y);
    logic [6:0] bin;
    bin = {3'b000, y[7:4]} * 7'd10 + {3'b000, y[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_en,
  input  logic clr,
  output logic step
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign step = osc_en && !clr && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (step)      cnt <= '0;
    else if (osc_en)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_wrap_counter.sv
module rtc_wrap_counter
  import rtc_pkg::*;
#(
  parameter logic [7:0] MINV = 8'h00,
  parameter logic [7:0] MAXV = 8'h59
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] val,
  output logic       carry
);
  logic at_top;
  assign at_top = (val >= MAXV);
  assign carry  = inc && !ld && at_top;

  always_ff @(posedge clk) begin
    if (!rst_n)   val <= MINV;
    else if (ld)  val <= ld_val;
    else if (inc) val <= at_top ? MINV : bcd_inc(val);
  end
endmodule

// File: rtl/rtc_date_unit.sv
module rtc_date_unit
  import rtc_pkg::*;
#(
  parameter logic [7:0] WDAY_MAX = 8'h06
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic [7:0] month_len,
  input  logic       ld_date,
  input  logic       ld_wday,
  input  logic [7:0] ld_val,
  output logic [7:0] date,
  output logic [7:0] wday,
  output logic       carry
);
  logic date_end;
  assign date_end = (date >= month_len);
  assign carry    = inc && !ld_date && date_end;

  always_ff @(posedge clk) begin
    if (!rst_n)       date <= 8'h01;
    else if (ld_date) date <= ld_val;
    else if (inc)     date <= date_end ? 8'h01 : bcd_inc(date);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       wday <= 8'h00;
    else if (ld_wday) wday <= ld_val;
    else if (inc)     wday <= (wday >= WDAY_MAX) ? 8'h00 : wday + 8'h01;
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] secs,
  output logic [7:0] mins,
  output logic [7:0] hours,
  output logic [7:0] mday,
  output logic [7:0] month,
  output logic [7:0] year,
  output logic [7:0] wday
);
  localparam int NTIME = 3;
  localparam logic [7:0] TIME_MAX [NTIME] = '{8'h59, 8'h59, 8'h23};

  logic                  sec_tick;
  logic [NUM_FIELDS-1:0] ld;
  logic [NTIME:0]        tchain;
  logic [7:0]            tval [NTIME];
  logic                  date_carry, month_carry, year_carry;
  logic [7:0]            mlen;

  always_comb begin
    ld = '0;
    if (wr_en && (wr_sel < 3'(NUM_FIELDS))) ld[wr_sel] = 1'b1;
  end

  rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .clr(wr_en), .step(sec_tick)
  );

  assign tchain[0] = sec_tick;

  for (genvar g = 0; g < NTIME; g++) begin : g_time
    rtc_wrap_counter #(.MINV(8'h00), .MAXV(TIME_MAX[g])) u_cnt (
      .clk(clk), .rst_n(rst_n), .inc(tchain[g]), .ld(ld[g]),
      .ld_val(wr_data), .val(tval[g]), .carry(tchain[g+1])
    );
  end

  assign secs  = tval[FLD_SEC];
  assign mins  = tval[FLD_MIN];
  assign hours = tval[FLD_HOUR];

  assign mlen = last_day(month, year_is_leap(year));

  rtc_date_unit u_date (
    .clk(clk), .rst_n(rst_n), .inc(tchain[NTIME]), .month_len(mlen),
    .ld_date(ld[FLD_DATE]), .ld_wday(ld[FLD_WDAY]), .ld_val(wr_data),
    .date(mday), .wday(wday), .carry(date_carry)
  );

  rtc_wrap_counter #(.MINV(8'h01), .MAXV(8'h12)) u_month (
    .clk(clk), .rst_n(rst_n), .inc(date_carry), .ld(ld[FLD_MONTH]),
    .ld_val(wr_data), .val(month), .carry(month_carry)
  );

  rtc_wrap_counter #(.MINV(8'h00), .MAXV(8'h99)) u_year (
    .clk(clk), .rst_n(rst_n), .inc(month_carry), .ld(ld[FLD_YEAR]),
    .ld_val(wr_data), .val(year), .carry(year_carry)
  );

  // year overflow has nowhere to go: the century is fixed
  logic unused_carry;
  assign unused_carry = year_carry;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic       sec_tick,
  input logic [7:0] secs,
  input logic [7:0] mins,
  input logic [7:0] hours,
  input logic [7:0] mday,
  input logic [7:0] month,
  input logic [7:0] year,
  input logic [7:0] wday
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !sec_tick |=> $stable(secs) && $stable(mins) && $stable(hours)
      && $stable(mday) && $stable(month) && $stable(year) && $stable(wday)); // R1

  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (secs <= 8'h59) && (secs[3:0] <= 4'd9)); // R2

  AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick && (secs == 8'h59) |=> (secs == 8'h00) && !$stable(mins)); // R3

  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> (wday <= 8'h06)); // R8

  AST_WDAY_WITH_DATE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mday) == $stable(wday))); // R8

  AST_WRITE_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (wr_sel == 3'd0) |=> (secs == $past(wr_data))); // R9

  AST_NO_STEP_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !sec_tick); // R10
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .sec_tick(sec_tick), .secs(secs), .mins(mins), .hours(hours), .mday(mday),
  .month(month), .year(year), .wday(wday)
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
  localparam int DIV = 4;

  typedef struct packed {
    logic [7:0] s, mi, h, d, mo, y, w;
  } snap_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] secs, mins, hours, mday, month, year, wday;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  snap_t exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  rtc_calendar #(.PRESCALE_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .secs(secs), .mins(mins), .hours(hours), .mday(mday),
    .month(month), .year(year), .wday(wday)
  );

  function automatic snap_t mk(input logic [7:0] s, mi, h, d, mo, y, w);
    snap_t t;
    t.s = s; t.mi = mi; t.h = h; t.d = d; t.mo = mo; t.y = y; t.w = w;
    return t;
  endfunction

  // monitor: pops expected snapshots and compares at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        snap_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = mk(secs, mins, hours, mday, month, year, wday);
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h (s mi h d mo y w)", t, a, e);
        end
      end
    end
  end

  task automatic expect_now(input snap_t e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v; osc_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(input logic [7:0] s, mi, h, d, mo, y, w);
    wr(3'd0, s); wr(3'd1, mi); wr(3'd2, h); wr(3'd3, d);
    wr(3'd4, mo); wr(3'd5, y); wr(3'd6, w);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      osc_en = 1'b1;
    end
    @(negedge clk);
    osc_en = 1'b0;
  endtask

  task automatic step_check(input snap_t start, input snap_t e, input string t);
    load_all(start.s, start.mi, start.h, start.d, start.mo, start.y, start.w);
    pulses(DIV);
    expect_now(e, t);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state
    expect_now(mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00), "R2 reset");

    // R1 one step per DIV pulses
    pulses(DIV - 1);
    expect_now(mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00), "R1 before step");
    pulses(1);
    expect_now(mk(8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00), "R1 step");
    // R1 idle enable: no change
    repeat (10) @(negedge clk);
    expect_now(mk(8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00), "R1 idle");

    // R2 digit carry
    step_check(mk(8'h09, 8'h12, 8'h07, 8'h03, 8'h08, 8'h17, 8'h01),
               mk(8'h10, 8'h12, 8'h07, 8'h03, 8'h08, 8'h17, 8'h01), "R2 digit carry");
    // R3 no carry below 59
    step_check(mk(8'h58, 8'h30, 8'h07, 8'h03, 8'h08, 8'h17, 8'h01),
               mk(8'h59, 8'h30, 8'h07, 8'h03, 8'h08, 8'h17, 8'h01), "R3 no carry");
    // R3 minute and hour carry, R8 no weekday change without date change
    step_check(mk(8'h59, 8'h59, 8'h05, 8'h10, 8'h03, 8'h24, 8'h02),
               mk(8'h00, 8'h00, 8'h06, 8'h10, 8'h03, 8'h24, 8'h02), "R3 R8 hour carry");
    // R4 day boundary, R8 weekday advance
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h15, 8'h05, 8'h23, 8'h03),
               mk(8'h00, 8'h00, 8'h00, 8'h16, 8'h05, 8'h23, 8'h04), "R4 R8 midnight");
    // R5 30-day month, R8 weekday wrap
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h25, 8'h06),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h25, 8'h00), "R5 R8 april end");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h30, 8'h05, 8'h25, 8'h00),
               mk(8'h00, 8'h00, 8'h00, 8'h31, 8'h05, 8'h25, 8'h01), "R5 may 30");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h31, 8'h05, 8'h25, 8'h01),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h06, 8'h25, 8'h02), "R5 may 31");
    // R6 February
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24, 8'h03),
               mk(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, 8'h04), "R6 leap 28");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h29, 8'h02, 8'h24, 8'h04),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h24, 8'h05), "R6 leap 29");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23, 8'h02),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, 8'h03), "R6 common 28");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00, 8'h01),
               mk(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h00, 8'h02), "R6 year 00");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h26, 8'h01),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h26, 8'h02), "R6 year 26");
    // R7 year boundaries
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h41, 8'h05),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h42, 8'h06), "R7 december");
    step_check(mk(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99, 8'h05),
               mk(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h06), "R7 year 99");

    // R9 single field write leaves others
    load_all(8'h11, 8'h22, 8'h13, 8'h14, 8'h07, 8'h33, 8'h04);
    wr(3'd1, 8'h42);
    expect_now(mk(8'h11, 8'h42, 8'h13, 8'h14, 8'h07, 8'h33, 8'h04), "R9 minute write");
    wr(3'd7, 8'h55);
    expect_now(mk(8'h11, 8'h42, 8'h13, 8'h14, 8'h07, 8'h33, 8'h04), "R9 code 7");

    // R10 write restarts prescaler
    pulses(DIV - 2);
    wr(3'd0, 8'h20);
    pulses(DIV - 1);
    expect_now(mk(8'h20, 8'h42, 8'h13, 8'h14, 8'h07, 8'h33, 8'h04), "R10 after write");
    pulses(1);
    expect_now(mk(8'h21, 8'h42, 8'h13, 8'h14, 8'h07, 8'h33, 8'h04), "R10 full period");

    while (exp_q.size() > 0) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule